// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This block prepares outgoing frames by walking a circular, linked list of transmit descriptors that software has placed in system memory. Each descriptor names a buffer and a byte count. The engine gathers the buffers of one or more consecutive owned descriptors into an internal frame store. It gives each descriptor back to software by writing its status word with the ownership bit cleared. When it reaches a descriptor flagged as the end of a frame, it plays the gathered bytes out on a valid/ready byte stream.

Software loads the list head through a small register interface and then starts the walk by writing the control register with the enable bit set. When the walk ends after at least one frame, the engine raises a sticky interrupt flag and clears the start bit of the control register. A walk whose gathered data would exceed the frame store marks the offending descriptor with a length error and stops.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, `irq`, `tx_valid` and `mem_req` are low, and the control, list and interrupt registers (selects 0, 1, 2) all read zero.
- R2: While the engine is idle, writing select 1 (list) loads both the head pointer and the current-descriptor pointer. Select 1 reads back the head and select 3 reads back the current pointer.
- R3: Writing select 0 (control) stores the value. If bit 30 is set and the engine is idle, a walk starts at the head. A descriptor at address A is read as four words: A+0 status, A+4 count/flags, A+8 buffer address, A+12 next-descriptor address.
- R4: A descriptor is processed only if bit 31 of its status word (ownership) is set. Before the first owned descriptor is found, unowned descriptors are skipped by following the next pointer. The search gives up without any effect when the next pointer equals the head.
- R5: The byte count is bits 10:0 of the count/flags word. The buffer starts at a word-aligned address and is read word by word, with byte k of a word taken from bits 8k+7:8k. Bytes from consecutive descriptors are appended in walk order.
- R6: Once a descriptor's buffer has been consumed, its status word is written back with bit 31 cleared and every other bit unchanged.
- R7: A frame is emitted only after a descriptor whose count/flags bit 30 (last) is set. `tx_last` marks its final byte. `tx_csum` is high when bits 28:27 of that last descriptor are non-zero.
- R8: After an owned descriptor has been processed, the walk moves to its next pointer. It ends at the first unowned descriptor and leaves bytes of an unfinished frame unsent.
- R9: The frame store holds 2048 bytes. A descriptor whose count would take the gathered total beyond 2048 is written back with bit 14 set and bit 31 kept, the walk stops, and nothing further is sent. A total of exactly 2048 is accepted.
- R10: When a walk ends after at least one frame, `irq` (select 2, bit 0) is set and control bit 31 is cleared. Writing 1 to select 2 bit 0 clears `irq`. If no frame was sent, both are left unchanged.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_valid` hold. A memory request holds its address and direction until `mem_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 control, 1 list head, 2 interrupt, 3 current descriptor |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_sel` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| tx_csum | output | 1 | Checksum insertion requested for this frame |
| irq | output | 1 | Transmit-complete interrupt flag |

## Verification
The case that is hardest to reach from the ports is the overflow check at the edge of the frame store. It needs a chain whose gathered length lands exactly on 2048 bytes, and another chain that goes one descriptor past it. The stimulus builds such chains in the bench's memory model, with a 2000-byte first buffer and a short second buffer. Granting is stalled every third cycle and the sink withholds ready every fourth, so both handshakes are exercised while this long gather runs. The circular search that ends back at the head, and a walk that stops on an unowned descriptor partway through a frame, are built the same way by clearing ownership bits in memory before the start.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int OWN_BIT    = 31;
    localparam int LENERR_BIT = 14;
    localparam int LAST_BIT   = 30;
    localparam int CS_HI      = 28;
    localparam int CS_LO      = 27;
    localparam int CNT_W      = 11;
    localparam int START_BIT  = 31;
    localparam int ENABLE_BIT = 30;

    typedef enum logic [2:0] {
        S_IDLE, S_DESC, S_DECIDE, S_BUF, S_WBACK, S_EMIT, S_NEXT, S_FINISH
    } walk_e;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0, REG_LIST = 2'd1, REG_IRQ = 2'd2, REG_CUR = 2'd3
    } reg_e;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  sel,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [31:0] cur_i,
    input  logic        done_i,
    output logic        kick_o,
    output logic        list_wr_o,
    output logic [31:0] head_o,
    output logic        irq_o
);
    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] head;
        logic        irq;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        kick_o    = 1'b0;
        list_wr_o = 1'b0;
        if (wr_en) begin
            case (reg_e'(sel))
                REG_CTRL: begin
                    r_d.ctrl = wdata;
                    kick_o   = wdata[ENABLE_BIT];
                end
                REG_LIST: begin
                    r_d.head  = wdata;
                    list_wr_o = 1'b1;
                end
                REG_IRQ:  if (wdata[0]) r_d.irq = 1'b0;
                default:  ;
            endcase
        end
        if (done_i) begin
            r_d.irq             = 1'b1;
            r_d.ctrl[START_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_e'(sel))
            REG_CTRL: rdata = r_q.ctrl;
            REG_LIST: rdata = r_q.head;
            REG_IRQ:  rdata = {31'd0, r_q.irq};
            default:  rdata = cur_i;
        endcase
    end

    assign head_o = r_q.head;
    assign irq_o  = r_q.irq;

    AST_DONE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (irq_o && !r_q.ctrl[START_BIT])); // R10
endmodule

// File: rtl/txd_fbuf.sv
module txd_fbuf #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [3:0]    wr_mask,
    input  logic [AW-1:0] wr_base,
    input  logic [31:0]   wr_word,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (wr_mask[k]) store_q[wr_base + AW'(k)] <= wr_word[8*k +: 8];
            end
        end
    end

    assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
    import txd_pkg::*;
#(
    parameter int FRAME_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [1:0]  csr_sel,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic        tx_csum,
    output logic        irq
);
    localparam int FAW = $clog2(FRAME_BYTES);
    localparam int FCW = FAW + 1;
    localparam int SW  = FCW + 1;

    typedef struct packed {
        walk_e            st;
        logic [1:0]       widx;
        logic             waiting;
        logic             searching;
        logic             err;
        logic             sent;
        logic [31:0]      cur;
        logic [31:0]      stat;
        logic [CNT_W-1:0] cnt;
        logic             last;
        logic             cs_req;
        logic [31:0]      bufp;
        logic [31:0]      nxt;
        logic [FCW-1:0]   fill;
        logic [CNT_W-1:0] remain;
        logic [FCW-1:0]   oidx;
        logic             csum;
    } eng_t;

    eng_t e_d, e_q;

    logic          kick, list_wr, done, fb_we;
    logic [31:0]   head;
    logic [3:0]    fb_mask;
    logic [2:0]    take;
    logic [7:0]    fb_rd;

    txd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(csr_we), .sel(csr_sel),
        .wdata(csr_wdata), .rdata(csr_rdata), .cur_i(e_q.cur),
        .done_i(done), .kick_o(kick), .list_wr_o(list_wr),
        .head_o(head), .irq_o(irq)
    );

    txd_fbuf #(.DEPTH(FRAME_BYTES)) u_fbuf (
        .clk(clk), .wr_en(fb_we), .wr_mask(fb_mask),
        .wr_base(e_q.fill[FAW-1:0]), .wr_word(mem_rdata),
        .rd_addr(e_q.oidx[FAW-1:0]), .rd_data(fb_rd)
    );

    assign take = (e_q.remain >= CNT_W'(4)) ? 3'd4 : e_q.remain[2:0];

    always_comb begin
        e_d       = e_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = e_q.cur;
        mem_wdata = e_q.stat;
        fb_we     = 1'b0;
        fb_mask   = '0;
        done      = 1'b0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        for (int k = 0; k < 4; k++) fb_mask[k] = (3'(k) < take);
        case (e_q.st)
            S_IDLE: begin
                if (list_wr) e_d.cur = csr_wdata;
                else if (kick) begin
                    e_d.cur = head;  e_d.searching = 1'b1;
                    e_d.sent = 1'b0; e_d.err = 1'b0;
                    e_d.fill = '0;   e_d.widx = '0;
                    e_d.st = S_DESC;
                end
            end
            S_DESC: begin
                mem_addr = e_q.cur + 32'({e_q.widx, 2'b00});
                if (!e_q.waiting) begin
                    mem_req = 1'b1;
                    if (mem_gnt) e_d.waiting = 1'b1;
                end else if (mem_rvalid) begin
                    e_d.waiting = 1'b0;
                    case (e_q.widx)
                        2'd0: e_d.stat = mem_rdata;
                        2'd1: begin
                            e_d.cnt    = mem_rdata[CNT_W-1:0];
                            e_d.last   = mem_rdata[LAST_BIT];
                            e_d.cs_req = |mem_rdata[CS_HI:CS_LO];
                        end
                        2'd2: e_d.bufp = mem_rdata;
                        default: e_d.nxt = mem_rdata;
                    endcase
                    if (e_q.widx == 2'd3) e_d.st = S_DECIDE;
                    else e_d.widx = e_q.widx + 2'd1;
                end
            end
            S_DECIDE: begin
                if (!e_q.stat[OWN_BIT]) begin
                    if (e_q.searching && e_q.nxt != head) begin
                        e_d.cur = e_q.nxt; e_d.widx = '0; e_d.st = S_DESC;
                    end else e_d.st = S_FINISH;
                end else begin
                    e_d.searching = 1'b0;
                    if ((SW'(e_q.fill) + SW'(e_q.cnt)) > SW'(FRAME_BYTES)) begin
                        e_d.stat[LENERR_BIT] = 1'b1;
                        e_d.err = 1'b1;
                        e_d.st  = S_WBACK;
                    end else begin
                        e_d.stat[OWN_BIT] = 1'b0;
                        e_d.remain = e_q.cnt;
                        e_d.st = (e_q.cnt == '0) ? S_WBACK : S_BUF;
                    end
                end
            end
            S_BUF: begin
                mem_addr = e_q.bufp;
                if (!e_q.waiting) begin
                    mem_req = 1'b1;
                    if (mem_gnt) e_d.waiting = 1'b1;
                end else if (mem_rvalid) begin
                    e_d.waiting = 1'b0;
                    fb_we       = 1'b1;
                    e_d.fill    = e_q.fill + FCW'(take);
                    e_d.remain  = e_q.remain - CNT_W'(take);
                    e_d.bufp    = e_q.bufp + 32'd4;
                    if (e_q.remain == CNT_W'(take)) e_d.st = S_WBACK;
                end
            end
            S_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_gnt) begin
                    if (e_q.err) e_d.st = S_FINISH;
                    else if (e_q.last) begin
                        e_d.csum = e_q.cs_req;
                        e_d.oidx = '0;
                        if (e_q.fill == '0) begin
                            e_d.sent = 1'b1; e_d.st = S_NEXT;
                        end else e_d.st = S_EMIT;
                    end else e_d.st = S_NEXT;
                end
            end
            S_EMIT: begin
                tx_valid = 1'b1;
                tx_last  = (e_q.oidx == e_q.fill - FCW'(1));
                if (tx_ready) begin
                    e_d.oidx = e_q.oidx + FCW'(1);
                    if (tx_last) begin
                        e_d.fill = '0; e_d.sent = 1'b1; e_d.st = S_NEXT;
                    end
                end
            end
            S_NEXT: begin
                e_d.cur  = e_q.nxt;
                e_d.widx = '0;
                e_d.st   = S_DESC;
            end
            default: begin
                done     = e_q.sent;
                e_d.st   = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign tx_data = fb_rd;
    assign tx_csum = e_q.csum;

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.fill <= FCW'(FRAME_BYTES)); // R9
    AST_ERR_KEEPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && e_q.err) |-> (mem_wdata[OWN_BIT] && mem_wdata[LENERR_BIT])); // R9
    AST_RETURN_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !e_q.err) |-> !mem_wdata[OWN_BIT]); // R6
    AST_EMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
endmodule

// File: tb/txdesc_dma_test.sv
module txdesc_dma_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, csr_we;
    logic [1:0]  csr_sel;
    logic [31:0] csr_wdata, csr_rdata;
    logic        mem_req, mem_we, mem_gnt, mem_rvalid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_ready, tx_last, tx_csum, irq;
    logic [7:0]  tx_data;

    txdesc_dma uut (.*);

    logic [31:0] mem [0:2047];
    logic [7:0]  rx_b [0:4095];
    int          rx_end [0:7];
    logic        rx_cs [0:7];
    int          rx_n, rx_frames;
    int          checks = 0, fails = 0;
    bit          finished = 0;

    // vector: ndesc[29:26] len0[25:18] len1[17:10] len2[9:2] csum[1:0]
    localparam logic [29:0] VEC [4] = '{
        {4'd1, 8'd5,  8'd0, 8'd0, 2'b00},
        {4'd2, 8'd3,  8'd6, 8'd0, 2'b10},
        {4'd3, 8'd4,  8'd1, 8'd7, 2'b01},
        {4'd1, 8'd64, 8'd0, 8'd0, 2'b11}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i, input int b);
        return 8'(seed * 37 + i * 11 + b * 3 + 1);
    endfunction

    task automatic put_byte(input int a, input logic [7:0] v);
        mem[a >> 2][8*(a % 4) +: 8] = v;
    endtask

    task automatic build_chain(input int n, input int l0, input int l1, input int l2,
                               input logic [1:0] cs, input int seed);
        for (int i = 0; i < n; i++) begin
            int len = (i == 0) ? l0 : (i == 1) ? l1 : l2;
            mem[4*i+0] = 32'h8000_0003 | (32'(i) << 4);
            mem[4*i+1] = 32'(len) | ((i == n-1) ? ((32'd1 << 30) | (32'(cs) << 27)) : 32'd0)
                         | ((i == 0) ? (32'd1 << 29) : 32'd0);
            mem[4*i+2] = 32'h200 + 32'h100 * i;
            mem[4*i+3] = (i == n-1) ? 32'd0 : 32'(16 * (i + 1));
            for (int b = 0; b < len; b++) put_byte(32'h200 + 32'h100 * i + b, pat(seed, i, b));
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic csr_wr(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk); csr_we = 1'b1; csr_sel = s; csr_wdata = v;
        @(negedge clk); csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk); csr_sel = s; #1 v = csr_rdata;
    endtask

    task automatic run_walk(input int cycles);
        rx_n = 0; rx_frames = 0;
        csr_wr(2'd1, 32'd0);
        csr_wr(2'd0, 32'hC000_0000);
        wait_cyc(cycles);
    endtask

    task automatic clear_irq();
        csr_wr(2'd2, 32'd1);
    endtask

    // memory model and stream sink
    initial begin
        int cyc = 0;
        bit pend = 0;
        logic [31:0] paddr = 0;
        mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0; tx_ready = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = pend;
            mem_rdata  = mem[paddr[12:2]];
            pend       = 0;
            mem_gnt    = mem_req && (cyc % 3 != 1);
            if (mem_gnt) begin
                if (mem_we) mem[mem_addr[12:2]] = mem_wdata;
                else begin pend = 1; paddr = mem_addr; end
            end
            tx_ready = (cyc % 4 != 3);
            if (tx_valid && tx_ready) begin
                rx_b[rx_n] = tx_data;
                rx_n++;
                if (tx_last) begin
                    rx_end[rx_frames] = rx_n;
                    rx_cs[rx_frames]  = tx_csum;
                    rx_frames++;
                end
            end
            cyc++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int k, bad, tot;
        rst_n = 0; csr_we = 0; csr_sel = 0; csr_wdata = 0;
        for (int i = 0; i < 2048; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(!irq && !tx_valid && !mem_req, "R1", "outputs after reset", {irq, tx_valid, mem_req}, 0);
        for (int s = 0; s < 3; s++) begin
            csr_rd(2'(s), v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end

        // R2: list write loads head and current pointer
        csr_wr(2'd1, 32'h40);
        csr_rd(2'd1, v); chk(v == 32'h40, "R2", "head readback", v, 32'h40);
        csr_rd(2'd3, v); chk(v == 32'h40, "R2", "current readback", v, 32'h40);

        // table of frame cases: R3 R5 R6 R7 R10
        for (int t = 0; t < 4; t++) begin
            int n = int'(VEC[t][29:26]);
            int lens [3];
            lens[0] = int'(VEC[t][25:18]); lens[1] = int'(VEC[t][17:10]); lens[2] = int'(VEC[t][9:2]);
            build_chain(n, lens[0], lens[1], lens[2], VEC[t][1:0], t + 1);
            run_walk(800);
            tot = 0; for (int i = 0; i < n; i++) tot += lens[i];
            chk(rx_frames == 1, "R7", "one frame per chain", rx_frames, 1);
            chk(rx_n == tot, "R5", "gathered length", rx_n, tot);
            k = 0; bad = 0;
            for (int i = 0; i < n; i++)
                for (int b = 0; b < lens[i]; b++) begin
                    if (rx_b[k] !== pat(t + 1, i, b)) bad++;
                    k++;
                end
            chk(bad == 0, "R5", "byte order mismatches", bad, 0);
            chk(rx_cs[0] == (VEC[t][1:0] != 0), "R7", "checksum flag", rx_cs[0], VEC[t][1:0] != 0);
            for (int i = 0; i < n; i++)
                chk(mem[4*i] == (32'h3 | (32'(i) << 4)), "R6", "returned status", mem[4*i], 32'h3 | (32'(i) << 4));
            chk(irq == 1'b1, "R10", "irq after frame", irq, 1);
            csr_rd(2'd0, v); chk(v == 32'h4000_0000, "R10", "start bit cleared", v, 32'h4000_0000);
            clear_irq(); #1;
            chk(irq == 1'b0, "R10", "irq cleared by write", irq, 0);
        end

        // R4: skip an unowned head descriptor
        build_chain(2, 5, 6, 0, 2'b00, 9);
        mem[0][31] = 1'b0;
        run_walk(600);
        chk(rx_frames == 1 && rx_n == 6, "R4", "frame from second descriptor", rx_n, 6);
        bad = 0; for (int b = 0; b < 6; b++) if (rx_b[b] !== pat(9, 1, b)) bad++;
        chk(bad == 0, "R4", "skipped data mismatches", bad, 0);
        chk(mem[0] == 32'h3, "R4", "unowned status untouched", mem[0], 32'h3);
        clear_irq();

        // R4: nothing owned, search returns to head
        build_chain(3, 4, 4, 4, 2'b00, 5);
        mem[0][31] = 1'b0; mem[4][31] = 1'b0; mem[8][31] = 1'b0;
        run_walk(400);
        chk(rx_frames == 0, "R4", "no frame when none owned", rx_frames, 0);
        chk(irq == 1'b0, "R10", "no irq when none owned", irq, 0);
        csr_rd(2'd0, v); chk(v == 32'hC000_0000, "R10", "start bit kept", v, 32'hC000_0000);
        chk(mem_req == 1'b0, "R4", "walk ended", mem_req, 0);

        // R7 R8: two frames in one walk
        build_chain(2, 4, 5, 0, 2'b01, 7);
        mem[1][30] = 1'b1;
        run_walk(800);
        chk(rx_frames == 2, "R8", "two frames sent", rx_frames, 2);
        chk(rx_end[0] == 4 && rx_n == 9, "R7", "frame boundary", rx_end[0], 4);
        chk(rx_cs[0] == 0 && rx_cs[1] == 1, "R7", "per-frame checksum", {rx_cs[0], rx_cs[1]}, 1);
        clear_irq();

        // R8: walk stops at unowned descriptor mid-frame
        build_chain(2, 4, 5, 0, 2'b00, 3);
        mem[4][31] = 1'b0;
        run_walk(600);
        chk(rx_frames == 0 && rx_n == 0, "R8", "partial frame not sent", rx_n, 0);
        chk(mem[0] == 32'h3, "R8", "first descriptor returned", mem[0], 32'h3);
        chk(irq == 1'b0, "R8", "no irq for partial frame", irq, 0);

        // R9: overflow by one descriptor
        mem[0] = 32'h8000_0003; mem[1] = 32'd2000; mem[2] = 32'h1000; mem[3] = 32'd16;
        mem[4] = 32'h8000_0013; mem[5] = 32'd100 | (32'd1 << 30); mem[6] = 32'h200; mem[7] = 32'd0;
        run_walk(4000);
        chk(rx_frames == 0 && rx_n == 0, "R9", "nothing sent on overflow", rx_n, 0);
        chk(mem[0] == 32'h3, "R9", "first returned", mem[0], 32'h3);
        chk(mem[4] == 32'h8000_4013, "R9", "length error status", mem[4], 32'h8000_4013);
        chk(irq == 1'b0, "R9", "no irq on overflow", irq, 0);

        // R9: exactly full frame store is accepted
        mem[0] = 32'h8000_0003; mem[4] = 32'h8000_0013;
        mem[5] = 32'd48 | (32'd1 << 30);
        run_walk(7000);
        chk(rx_frames == 1 && rx_n == 2048, "R9", "full 2048-byte frame", rx_n, 2048);
        chk(mem[4] == 32'h13, "R9", "last returned", mem[4], 32'h13);
        chk(irq == 1'b1, "R10", "irq after full frame", irq, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule